// File: doc/BRIEF.md
# Inter-core supplemental interrupt register

This block is a shared register word. Two processor cores use it to send sticky interrupt requests to each other. Each core has its own register port: a request strobe, a write enable, write data, returned read data and a one-cycle acknowledge. The word holds four request bits, one for each pairing of source core and target core. A core raises a request by writing a one into the set field. The request then stays high until some write carries a one in the matching position of the clear field.

Reads return the live request status, so software can poll a request it raised and wait for the target core to clear it. The same status drives four interrupt outputs toward an interrupt controller. Each output is gated by its own bit of an enable mask input. A request that is masked is still held and can still be read.

Top module: `xcore_sirq_reg`

## Requirements
- R1: Writing a 1 to a set bit, bits [9:6], raises that request from the clock edge that samples the write. The bit mapping is: bit 6 is core A to core A, bit 7 is core A to core B, bit 8 is core B to core A, and bit 9 is core B to core B.
- R2: Writing a 1 to clear bit n+4, bits [13:10], clears the request held in bit n, for n from 6 to 9.
- R3: A request stays set through every later write that has no 1 in its clear position. Writing 0 to any set or clear bit has no effect.
- R4: A read is acknowledged one cycle after its request. The returned data carries the status of the four requests in bits [9:6], as it stood in the cycle the read was requested, which is before any write sampled at that same edge. All other bits return 0, including bits [13:10]. The read data is 0 on a write acknowledge.
- R5: Either core may write any set or clear bit. One write from a single core may raise requests on both target cores.
- R6: When a write, or two writes from different cores in the same cycle, both set and clear the same request, the set wins.
- R7: When both cores write in the same cycle, their set fields are ORed, their clear fields are ORed, and the result is applied as one update.
- R8: irq_o[k] is high exactly when request bit 6+k is set and en_mask_i[k] is 1. The status bit can be read whatever the mask holds.
- R9: Every accepted request on a port gives one ack_o pulse, one cycle wide, in the following cycle. A port with no request gives no acknowledge.
- R10: An active-low asynchronous reset clears all requests, both acknowledges and both read data outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_req_i | input | 1 | Core A access request |
| a_we_i | input | 1 | Core A write enable (0 = read) |
| a_wdata_i | input | 16 | Core A write data |
| a_rdata_o | output | 16 | Core A read data, valid with a_ack_o |
| a_ack_o | output | 1 | Core A acknowledge |
| b_req_i | input | 1 | Core B access request |
| b_we_i | input | 1 | Core B write enable (0 = read) |
| b_wdata_i | input | 16 | Core B write data |
| b_rdata_o | output | 16 | Core B read data, valid with b_ack_o |
| b_ack_o | output | 1 | Core B acknowledge |
| en_mask_i | input | 4 | Per-request interrupt enable |
| irq_o | output | 4 | Masked request outputs |

## Verification
Two functions can fall in the same cycle: a set and a clear aimed at the same request, and a read of the status while the other core writes it. The bench provokes both. It drives set and clear together in a single write, and again across both ports in one cycle. In another cycle it puts a read on one port and a write on the other. A reference model judges the results: the set must win, and the read must return the status from before the write. A scoreboard matches each acknowledge against its expected read data.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned SIRQ_N_PORTS = 2;
  localparam int unsigned SIRQ_N_REQ   = 4;
  typedef enum logic {CORE_A = 1'b0, CORE_B = 1'b1} core_e;
endpackage

// File: rtl/sirq_port_dec.sv
module sirq_port_dec #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SET_LSB = 6,
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_REQ-1:0] status_i,
  output logic [NUM_REQ-1:0] set_o,
  output logic [NUM_REQ-1:0] clr_o,
  output logic               ack_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned CLR_LSB = SET_LSB + NUM_REQ;

  logic              wr;
  logic [DATA_W-1:0] unused_wdata;

  assign wr           = req_i && we_i;
  assign set_o        = wr ? wdata_i[SET_LSB +: NUM_REQ] : '0;
  assign clr_o        = wr ? wdata_i[CLR_LSB +: NUM_REQ] : '0;
  assign unused_wdata = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= '0;
      if (req_i && !we_i) rdata_o[SET_LSB +: NUM_REQ] <= status_i;
    end
  end

  // R9
  ack_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  // R9
  no_spurious_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  // R4
  rd_field_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> (rdata_o[SET_LSB +: NUM_REQ] == $past(status_i)));
endmodule

// File: rtl/sirq_store.sv
module sirq_store #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned N_PORTS = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS-1:0][NUM_REQ-1:0] set_i,
  input  logic [N_PORTS-1:0][NUM_REQ-1:0] clr_i,
  output logic [NUM_REQ-1:0]              status_o
);
  logic [NUM_REQ-1:0] set_all, clr_all, status_q;

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      set_all = set_all | set_i[p];
      clr_all = clr_all | clr_i[p];
    end
  end

  // set has priority so a request raised in the same cycle is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_all) | set_all;
  end

  assign status_o = status_q;

  // R1
  set_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_all) |=> (($past(set_all) & ~status_q) == '0));
  // R2
  clr_lowers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_all & ~set_all)) |=> (($past(clr_all & ~set_all) & status_q) == '0));
  // R3
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_q) |=> ((($past(status_q) & ~$past(clr_all)) & ~status_q) == '0));
  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_all & clr_all)) |=> (($past(set_all & clr_all) & ~status_q) == '0));
endmodule

// File: rtl/sirq_gate.sv
module sirq_gate #(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic [NUM_REQ-1:0] status_i,
  input  logic [NUM_REQ-1:0] mask_i,
  output logic [NUM_REQ-1:0] irq_o
);
  for (genvar k = 0; k < NUM_REQ; k++) begin : g_irq
    assign irq_o[k] = status_i[k] & mask_i[k];
  end
endmodule

// File: rtl/xcore_sirq_reg.sv
module xcore_sirq_reg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SET_LSB = 6,
  parameter int unsigned NUM_REQ = sirq_pkg::SIRQ_N_REQ
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_req_i,
  input  logic               a_we_i,
  input  logic [DATA_W-1:0]  a_wdata_i,
  output logic [DATA_W-1:0]  a_rdata_o,
  output logic               a_ack_o,
  input  logic               b_req_i,
  input  logic               b_we_i,
  input  logic [DATA_W-1:0]  b_wdata_i,
  output logic [DATA_W-1:0]  b_rdata_o,
  output logic               b_ack_o,
  input  logic [NUM_REQ-1:0] en_mask_i,
  output logic [NUM_REQ-1:0] irq_o
);
  import sirq_pkg::*;
  localparam int unsigned NP = SIRQ_N_PORTS;

  logic [NP-1:0]              req, we, ack;
  logic [NP-1:0][DATA_W-1:0]  wdata, rdata;
  logic [NP-1:0][NUM_REQ-1:0] set_m, clr_m;
  logic [NUM_REQ-1:0]         status;

  assign req[CORE_A]   = a_req_i;
  assign we[CORE_A]    = a_we_i;
  assign wdata[CORE_A] = a_wdata_i;
  assign req[CORE_B]   = b_req_i;
  assign we[CORE_B]    = b_we_i;
  assign wdata[CORE_B] = b_wdata_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    sirq_port_dec #(.DATA_W(DATA_W), .SET_LSB(SET_LSB), .NUM_REQ(NUM_REQ)) u_dec (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req[p]), .we_i(we[p]),
      .wdata_i(wdata[p]), .status_i(status), .set_o(set_m[p]), .clr_o(clr_m[p]),
      .ack_o(ack[p]), .rdata_o(rdata[p]));
  end

  sirq_store #(.NUM_REQ(NUM_REQ), .N_PORTS(NP)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_m), .clr_i(clr_m), .status_o(status));

  sirq_gate #(.NUM_REQ(NUM_REQ)) u_gate (
    .status_i(status), .mask_i(en_mask_i), .irq_o(irq_o));

  assign a_rdata_o = rdata[CORE_A];
  assign a_ack_o   = ack[CORE_A];
  assign b_rdata_o = rdata[CORE_B];
  assign b_ack_o   = ack[CORE_B];

  // R8
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~en_mask_i) == '0));
endmodule

// File: tb/xcore_sirq_reg_bench.sv
module xcore_sirq_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [15:0] a_wd = '0, b_wd = '0;
  logic [15:0] a_rd, b_rd;
  logic        a_ack, b_ack;
  logic [3:0]  mask = 4'hF;
  logic [3:0]  irq;

  int n_chk = 0, n_fail = 0;
  logic [3:0]  m = '0;
  logic [15:0] q_a[$], q_b[$];
  string       t_a[$], t_b[$];

  always #2 clk = ~clk;

  xcore_sirq_reg u_xcore_sirq_reg (
    .clk_i(clk), .rst_ni(rst_n),
    .a_req_i(a_req), .a_we_i(a_we), .a_wdata_i(a_wd), .a_rdata_o(a_rd), .a_ack_o(a_ack),
    .b_req_i(b_req), .b_we_i(b_we), .b_wdata_i(b_wd), .b_rdata_o(b_rd), .b_ack_o(b_ack),
    .en_mask_i(mask), .irq_o(irq));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus on both ports, expectations pushed to the scoreboard
  task automatic cyc(input logic ra, input logic wa, input logic [15:0] da,
                     input logic rb, input logic wb, input logic [15:0] db, input string tag);
    logic [3:0] s, c;
    @(negedge clk);
    a_req = ra; a_we = wa; a_wd = da;
    b_req = rb; b_we = wb; b_wd = db;
    if (ra) begin q_a.push_back(wa ? 16'h0 : (16'(m) << 6)); t_a.push_back(tag); end
    if (rb) begin q_b.push_back(wb ? 16'h0 : (16'(m) << 6)); t_b.push_back(tag); end
    s = ((ra && wa) ? da[9:6]   : 4'h0) | ((rb && wb) ? db[9:6]   : 4'h0);
    c = ((ra && wa) ? da[13:10] : 4'h0) | ((rb && wb) ? db[13:10] : 4'h0);
    m = (m & ~c) | s;
  endtask

  task automatic idle();
    cyc(0, 0, 16'h0, 0, 0, 16'h0, "idle");
  endtask

  task automatic wr_a(logic [15:0] d, string tag); cyc(1, 1, d, 0, 0, 16'h0, tag); endtask
  task automatic wr_b(logic [15:0] d, string tag); cyc(0, 0, 16'h0, 1, 1, d, tag); endtask
  task automatic rd_a(string tag); cyc(1, 0, 16'h0, 0, 0, 16'h0, tag); endtask
  task automatic rd_b(string tag); cyc(0, 0, 16'h0, 1, 0, 16'h0, tag); endtask

  // monitor: pops an expectation on every acknowledge
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_ack) begin
        if (q_a.size() == 0) check("R9 port A spurious ack", 16'h1, 16'h0);
        else check({t_a.pop_front(), " port A"}, a_rd, q_a.pop_front());
      end
      if (b_ack) begin
        if (q_b.size() == 0) check("R9 port B spurious ack", 16'h1, 16'h0);
        else check({t_b.pop_front(), " port B"}, b_rd, q_b.pop_front());
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset irq", 16'(irq), 16'h0);
    check("R10 reset ack", {14'h0, a_ack, b_ack}, 16'h0);
    check("R10 reset rdata", a_rd | b_rd, 16'h0);
    rst_n = 1'b1;
    rd_a("R10 read after reset");
    wr_a(16'h0080, "R1 A sets bit7");
    rd_b("R1 status bit7");
    idle();
    check("R8 irq bit7", 16'(irq), 16'(m & mask));
    wr_a(16'h0040, "R1 A sets bit6");
    wr_a(16'h0000, "R3 zero write");
    wr_b(16'hC03F, "R3 bits outside fields");
    rd_a("R3 sticky status");
    wr_b(16'h0800, "R2 B clears bit7");
    rd_b("R2 status after clear");
    wr_a(16'h2200, "R6 set and clear bit9 one write");
    rd_a("R6 bit9 survives");
    cyc(1, 1, 16'h0100, 1, 1, 16'h1000, "R6 cross-port set vs clear bit8");
    rd_b("R6 bit8 survives");
    wr_b(16'h3C00, "R2 clear all");
    cyc(1, 1, 16'h0040, 1, 1, 16'h0080, "R7 both set");
    rd_a("R7 OR of sets");
    cyc(1, 1, 16'h0400, 1, 1, 16'h0800, "R7 both clear");
    rd_b("R7 OR of clears");
    wr_a(16'h0180, "R5 A raises both targets");
    rd_b("R5 status");
    mask = 4'h0;
    idle();
    check("R8 mask zero irq", 16'(irq), 16'h0);
    rd_a("R8 masked still readable");
    mask = 4'h5;
    idle();
    check("R8 partial mask irq", 16'(irq), 16'(m & mask));
    wr_b(16'hFFFF, "R5 B writes all");
    rd_a("R4 clear field reads zero");
    cyc(1, 0, 16'h0, 1, 1, 16'h3C00, "R4 read during other core write");
    rd_a("R4 status after write");
    mask = 4'hF;
    wr_b(16'h0200, "R1 B sets bit9");
    idle();
    check("R8 irq bit9", 16'(irq), 16'(m & mask));
    rd_a("R9 back to back 1");
    rd_a("R9 back to back 2");
    idle(); idle(); idle();
    check("R9 queue A drained", 16'(q_a.size()), 16'h0);
    check("R9 queue B drained", 16'(q_b.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule